// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and End-of-Interrupt Unit

This unit sits between a priority interrupt controller's source logic and one processor. The source side offers forward requests, one source index per cycle. The source side also presents the current priority, vector, activity flag and sense of every source. The unit keeps two bitmaps. The pending map holds sources that have been delivered to this processor but not yet taken. The in-service map holds sources that have been taken but not yet ended. The unit holds a 4-bit task priority and drives the processor's interrupt line.

The processor talks to the unit through a small register port. It reads a vector from the acknowledge register, writes the end-of-interrupt register when a handler is done, and sets its task priority. Acknowledge picks the most urgent pending source. It then returns either that source's vector or a programmable spurious vector, and it can pulse a per-source strobe that tells the source logic to drop the source's activity flag. End-of-interrupt retires the most urgent in-service source. It then compares what is still pending against what is still in service, to decide whether the line should rise again.

Top module: `irq_cpu_port`

## Requirements
- R1: The most urgent member of a map is the member with the highest 5-bit priority. Among equal priorities the lowest source index wins.
- R2: The task priority is written at address 0x80, and only write-data bits [3:0] are kept. It resets to 0xF. A read of 0x80 returns it zero-extended.
- R3: A forward request is dropped, leaving the line and the pending map unchanged, when the source priority is not strictly greater than the task priority. A source that is already pending is also dropped.
- R4: An accepted forward whose priority is strictly greater than the highest pending priority before the forward sets cpu_irq in the next cycle.
- R5: A read of the acknowledge address 0xA0 with an empty pending map returns the spurious vector. The spurious vector is an 8-bit register at 0xE0 that resets to 0xFF and keeps write-data bits [7:0]. Read data appears on rd_data one cycle after the read strobe, zero-extended.
- R6: If the selected pending source is inactive, or its priority is no longer above the task priority, acknowledge returns the spurious vector and pulses that source's act_clr bit. The source does not enter the in-service map.
- R7: Acknowledge always removes the selected source from the pending map. A valid acknowledge returns the source's vector and moves the source into the in-service map. For an edge-sensitive source (src_level bit = 0) it also pulses act_clr bit <index> for one cycle. For a level-sensitive source it leaves act_clr at zero.
- R8: A write to 0xB0 removes the most urgent in-service source. cpu_irq is then set if the highest pending priority exceeds the highest remaining in-service priority. An empty map counts as priority 0.
- R9: Writes to 0x90 and 0xA0 have no effect on the line, the maps or the task priority.
- R10: After an acknowledge, cpu_irq is cleared unless the highest remaining pending priority exceeds the highest in-service priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fwd_valid | input | 1 | Forward request strobe |
| fwd_id | input | 5 | Index of the forwarded source |
| src_prio | input | 160 | Packed 5-bit priority per source |
| src_vec | input | 256 | Packed 8-bit vector per source |
| src_active | input | 32 | Activity flag per source |
| src_level | input | 32 | 1 = level-sensitive, 0 = edge-sensitive |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after reg_rd |
| cpu_irq | output | 1 | Interrupt line to the processor |
| act_clr | output | 32 | One-cycle strobes that clear a source's activity flag |

## Verification
Every result is registered once. So read data, the interrupt line and the activity-clear strobes all change at the first clock edge after the request or register strobe that causes them. The bench drives each stimulus on a falling edge and drops it on the next falling edge. It then checks cpu_irq and act_clr at that falling edge, half a cycle after the edge that updated them. Each acknowledge or register read pushes its expected word into a queue. A monitor sees the read strobe at a rising edge and pops and compares rd_data at the following falling edge. No check therefore sits on the edge where the value moves.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;
  localparam int DEF_NSRC   = 32;
  localparam int DEF_PRIO_W = 5;
  localparam int DEF_TASK_W = 4;
  localparam int DEF_VEC_W  = 8;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_ADDR_W = 8;

  localparam logic [7:0] ADR_TASK = 8'h80;
  localparam logic [7:0] ADR_ID   = 8'h90;
  localparam logic [7:0] ADR_ACK  = 8'hA0;
  localparam logic [7:0] ADR_EOI  = 8'hB0;
  localparam logic [7:0] ADR_SPUR = 8'hE0;

  // strict comparison of a source priority against the task threshold
  function automatic logic above_task(input logic [DEF_PRIO_W-1:0] p,
                                      input logic [DEF_TASK_W-1:0] t);
    return p > DEF_PRIO_W'(t);
  endfunction
endpackage

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 5,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        members,
  input  logic [NSRC*PRIO_W-1:0] prio,
  output logic                   any,
  output logic [IDX_W-1:0]       idx,
  output logic [PRIO_W-1:0]      best
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (members[i] && (!any || prio[i*PRIO_W +: PRIO_W] > best)) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_set_update.sv
module irq_set_update #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 5,
  parameter int TASK_W = 4,
  parameter int VEC_W  = 8,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        raised_q,
  input  logic [NSRC-1:0]        serv_q,
  input  logic [NSRC*PRIO_W-1:0] src_prio,
  input  logic [NSRC*VEC_W-1:0]  src_vec,
  input  logic [NSRC-1:0]        src_active,
  input  logic [NSRC-1:0]        src_level,
  input  logic [TASK_W-1:0]      tpr_q,
  input  logic [VEC_W-1:0]       spur_q,
  input  logic                   fwd_accept,
  input  logic [IDX_W-1:0]       fwd_id,
  input  logic                   ack_fire,
  input  logic                   eoi_fire,
  input  logic                   r_any,
  input  logic [IDX_W-1:0]       r_idx,
  input  logic                   s_any,
  input  logic [IDX_W-1:0]       s_idx,
  output logic                   ack_stale,
  output logic [VEC_W-1:0]       ack_word,
  output logic [NSRC-1:0]        raised_nxt,
  output logic [NSRC-1:0]        serv_nxt,
  output logic [NSRC-1:0]        act_clr_nxt
);
  logic [PRIO_W-1:0] sel_prio;
  logic [VEC_W-1:0]  sel_vec;
  logic              sel_act;
  logic              sel_lvl;
  logic              ack_take;

  assign sel_prio  = src_prio[r_idx*PRIO_W +: PRIO_W];
  assign sel_vec   = src_vec[r_idx*VEC_W +: VEC_W];
  assign sel_act   = src_active[r_idx];
  assign sel_lvl   = src_level[r_idx];
  assign ack_stale = !sel_act || !(sel_prio > PRIO_W'(tpr_q));
  assign ack_take  = ack_fire && r_any;
  assign ack_word  = (!r_any || ack_stale) ? spur_q : sel_vec;

  always_comb begin
    raised_nxt  = raised_q;
    serv_nxt    = serv_q;
    act_clr_nxt = '0;
    if (fwd_accept) raised_nxt[fwd_id] = 1'b1;
    if (ack_take) begin
      raised_nxt[r_idx] = 1'b0;
      if (!ack_stale) serv_nxt[r_idx] = 1'b1;
      if (ack_stale || !sel_lvl) act_clr_nxt[r_idx] = 1'b1;
    end
    if (eoi_fire && s_any) serv_nxt[s_idx] = 1'b0;
  end
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import irq_cpu_pkg::*;
#(
  parameter int NSRC   = DEF_NSRC,
  parameter int PRIO_W = DEF_PRIO_W,
  parameter int TASK_W = DEF_TASK_W,
  parameter int VEC_W  = DEF_VEC_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int ADDR_W = DEF_ADDR_W,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fwd_valid,
  input  logic [IDX_W-1:0]       fwd_id,
  input  logic [NSRC*PRIO_W-1:0] src_prio,
  input  logic [NSRC*VEC_W-1:0]  src_vec,
  input  logic [NSRC-1:0]        src_active,
  input  logic [NSRC-1:0]        src_level,
  input  logic                   reg_rd,
  input  logic                   reg_wr,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   cpu_irq,
  output logic [NSRC-1:0]        act_clr
);
  logic [NSRC-1:0]   raised_q, serv_q;
  logic [TASK_W-1:0] tpr_q;
  logic [VEC_W-1:0]  spur_q;
  logic              irq_q;
  logic [NSRC-1:0]   act_clr_q;
  logic [DATA_W-1:0] rd_q;

  // named events for the checker
  logic              fwd_accept, fwd_raise, ack_fire, eoi_fire;
  logic              raised_any, serv_any;
  logic [IDX_W-1:0]  r_idx, s_idx;
  logic [PRIO_W-1:0] r_best, s_best, fwd_prio;
  logic              ack_stale;
  logic [VEC_W-1:0]  ack_word;
  logic [NSRC-1:0]   raised_nxt, serv_nxt, act_clr_nxt;
  logic              rn_any, sn_any;
  logic [IDX_W-1:0]  rn_idx, sn_idx;
  logic [PRIO_W-1:0] rn_best, sn_best;
  logic              cmp_nxt, irq_nxt;
  logic [DATA_W-1:0] rd_nxt;

  irq_prio_find #(.NSRC(NSRC), .PRIO_W(PRIO_W)) find_raised_i (
    .members(raised_q), .prio(src_prio), .any(raised_any), .idx(r_idx), .best(r_best));
  irq_prio_find #(.NSRC(NSRC), .PRIO_W(PRIO_W)) find_serv_i (
    .members(serv_q), .prio(src_prio), .any(serv_any), .idx(s_idx), .best(s_best));

  assign fwd_prio   = src_prio[fwd_id*PRIO_W +: PRIO_W];
  assign fwd_accept = fwd_valid && (fwd_prio > PRIO_W'(tpr_q)) && !raised_q[fwd_id];
  assign fwd_raise  = fwd_accept && (fwd_prio > r_best);
  assign ack_fire   = reg_rd && (reg_addr == ADDR_W'(ADR_ACK));
  assign eoi_fire   = reg_wr && (reg_addr == ADDR_W'(ADR_EOI));

  irq_set_update #(.NSRC(NSRC), .PRIO_W(PRIO_W), .TASK_W(TASK_W), .VEC_W(VEC_W)) upd_i (
    .raised_q(raised_q), .serv_q(serv_q), .src_prio(src_prio), .src_vec(src_vec),
    .src_active(src_active), .src_level(src_level), .tpr_q(tpr_q), .spur_q(spur_q),
    .fwd_accept(fwd_accept), .fwd_id(fwd_id), .ack_fire(ack_fire), .eoi_fire(eoi_fire),
    .r_any(raised_any), .r_idx(r_idx), .s_any(serv_any), .s_idx(s_idx),
    .ack_stale(ack_stale), .ack_word(ack_word), .raised_nxt(raised_nxt),
    .serv_nxt(serv_nxt), .act_clr_nxt(act_clr_nxt));

  irq_prio_find #(.NSRC(NSRC), .PRIO_W(PRIO_W)) find_rn_i (
    .members(raised_nxt), .prio(src_prio), .any(rn_any), .idx(rn_idx), .best(rn_best));
  irq_prio_find #(.NSRC(NSRC), .PRIO_W(PRIO_W)) find_sn_i (
    .members(serv_nxt), .prio(src_prio), .any(sn_any), .idx(sn_idx), .best(sn_best));

  assign cmp_nxt = rn_best > sn_best;
  assign irq_nxt = ack_fire ? cmp_nxt : (irq_q || fwd_raise || (eoi_fire && cmp_nxt));

  always_comb begin
    rd_nxt = '0;
    if (reg_rd) begin
      if (reg_addr == ADDR_W'(ADR_TASK))      rd_nxt = DATA_W'(tpr_q);
      else if (reg_addr == ADDR_W'(ADR_SPUR)) rd_nxt = DATA_W'(spur_q);
      else if (reg_addr == ADDR_W'(ADR_ACK))  rd_nxt = DATA_W'(ack_word);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raised_q  <= '0;
      serv_q    <= '0;
      tpr_q     <= '1;
      spur_q    <= '1;
      irq_q     <= 1'b0;
      act_clr_q <= '0;
      rd_q      <= '0;
    end else begin
      raised_q  <= raised_nxt;
      serv_q    <= serv_nxt;
      irq_q     <= irq_nxt;
      act_clr_q <= act_clr_nxt;
      rd_q      <= rd_nxt;
      if (reg_wr && reg_addr == ADDR_W'(ADR_TASK)) tpr_q  <= reg_wdata[TASK_W-1:0];
      if (reg_wr && reg_addr == ADDR_W'(ADR_SPUR)) spur_q <= reg_wdata[VEC_W-1:0];
    end
  end

  assign rd_data = rd_q;
  assign cpu_irq = irq_q;
  assign act_clr = act_clr_q;
endmodule

// File: rtl/irq_cpu_port_chk.sv
module irq_cpu_port_chk #(
  parameter int NSRC   = 32,
  parameter int TASK_W = 4,
  parameter int VEC_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              fwd_valid,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              cpu_irq,
  input logic [NSRC-1:0]   act_clr,
  input logic [TASK_W-1:0] tpr_q,
  input logic [VEC_W-1:0]  spur_q,
  input logic [NSRC-1:0]   raised_q,
  input logic [NSRC-1:0]   serv_q,
  input logic              raised_any,
  input logic              fwd_raise,
  input logic              ack_fire,
  input logic              eoi_fire
);
  // R7
  act_clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_clr));

  // R2
  tpr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR_W'(8'h80)) |=> $stable(tpr_q));

  // R5
  empty_ack_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !raised_any) |=> rd_data == DATA_W'($past(spur_q)));

  // R4
  fwd_raise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_raise && !ack_fire) |=> cpu_irq);

  // R8
  eoi_retire_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !ack_fire && serv_q != '0) |=>
      $countones(serv_q) == $countones($past(serv_q)) - 1);

  // R9
  ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rd && !fwd_valid &&
     (reg_addr == ADDR_W'(8'h90) || reg_addr == ADDR_W'(8'hA0))) |=>
      ($stable(raised_q) && $stable(serv_q)));
endmodule

bind irq_cpu_port irq_cpu_port_chk #(
  .NSRC(NSRC), .TASK_W(TASK_W), .VEC_W(VEC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .fwd_valid(fwd_valid),
  .reg_addr(reg_addr), .rd_data(rd_data), .cpu_irq(cpu_irq), .act_clr(act_clr),
  .tpr_q(tpr_q), .spur_q(spur_q), .raised_q(raised_q), .serv_q(serv_q),
  .raised_any(raised_any), .fwd_raise(fwd_raise), .ack_fire(ack_fire),
  .eoi_fire(eoi_fire)
);

// File: tb/irq_cpu_port_tb_top.sv
module irq_cpu_port_tb_top;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fwd_valid = 1'b0;
  logic [4:0]    fwd_id = '0;
  logic [N*5-1:0] src_prio;
  logic [N*8-1:0] src_vec;
  logic [N-1:0]  src_active, src_level;
  logic          reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   rd_data;
  logic          cpu_irq;
  logic [N-1:0]  act_clr;

  logic [4:0] sp [N];
  logic [7:0] sv [N];
  logic       sa [N];
  logic       sl [N];

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      src_prio[i*5 +: 5] = sp[i];
      src_vec[i*8 +: 8]  = sv[i];
      src_active[i]      = sa[i];
      src_level[i]       = sl[i];
    end
  end

  irq_cpu_port dut_i (
    .clk(clk), .rst_n(rst_n), .fwd_valid(fwd_valid), .fwd_id(fwd_id),
    .src_prio(src_prio), .src_vec(src_vec), .src_active(src_active),
    .src_level(src_level), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .cpu_irq(cpu_irq), .act_clr(act_clr));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: read strobe seen at a rising edge, data compared at the next falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk("scoreboard underflow", 64'd1, 64'd0);
        else chk(tag_q.pop_front(), 64'(rd_data), 64'(exp_q.pop_front()));
      end
    end
  end

  task automatic fwd(int id);
    @(negedge clk); fwd_valid = 1'b1; fwd_id = 5'(id);
    @(negedge clk); fwd_valid = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      sp[i] = '0; sv[i] = 8'(i + 32); sa[i] = 1'b1; sl[i] = 1'b0;
    end
    sl[2] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R4 reset irq low", 64'(cpu_irq), 64'd0);
    chk("R7 reset act_clr", 64'(act_clr), 64'd0);
    rd(8'h80, 32'hF, "R2 reset task priority");
    rd(8'hE0, 32'hFF, "R5 reset spurious");
    rd(8'hA0, 32'hFF, "R5 empty ack");

    // R3: below threshold 0xF
    sp[3] = 5'd10; fwd(3);
    chk("R3 below task ignored irq", 64'(cpu_irq), 64'd0);
    rd(8'hA0, 32'hFF, "R3 below task not pending");

    wr(8'h80, 32'h123);
    rd(8'h80, 32'h3, "R2 low bits kept");

    // R3: equal to threshold is dropped
    sp[12] = 5'd3; fwd(12);
    chk("R3 equal task ignored irq", 64'(cpu_irq), 64'd0);
    rd(8'hA0, 32'hFF, "R3 equal task not pending");

    // tie and nesting
    sp[5] = 5'd6; fwd(5);
    chk("R4 forward asserts irq", 64'(cpu_irq), 64'd1);
    sp[2] = 5'd6; fwd(2);
    rd(8'hA0, 32'h22, "R1 tie lowest index");
    chk("R7 level no act_clr", 64'(act_clr), 64'd0);
    chk("R10 irq low after ack", 64'(cpu_irq), 64'd0);
    wr(8'hB0, 32'h0);
    chk("R8 eoi reasserts irq", 64'(cpu_irq), 64'd1);
    rd(8'hA0, 32'h25, "R7 edge ack vector");
    chk("R7 edge act_clr", 64'(act_clr), 64'(32'h1 << 5));
    chk("R10 irq low with empty pending", 64'(cpu_irq), 64'd0);
    wr(8'hB0, 32'h0);
    chk("R8 eoi nothing pending", 64'(cpu_irq), 64'd0);

    // stale: inactive
    sp[7] = 5'd9; fwd(7);
    chk("R4 irq for src7", 64'(cpu_irq), 64'd1);
    sa[7] = 1'b0;
    rd(8'hA0, 32'hFF, "R6 inactive gives spurious");
    chk("R6 inactive act_clr", 64'(act_clr), 64'(32'h1 << 7));
    chk("R10 irq low after stale", 64'(cpu_irq), 64'd0);
    sa[7] = 1'b1;
    rd(8'hA0, 32'hFF, "R7 stale removed from pending");
    chk("R7 no strobe on empty", 64'(act_clr), 64'd0);

    // stale: priority dropped to threshold or below
    sp[8] = 5'd9; fwd(8);
    sp[8] = 5'd2;
    rd(8'hA0, 32'hFF, "R6 priority dropped gives spurious");
    chk("R6 priority drop act_clr", 64'(act_clr), 64'(32'h1 << 8));

    wr(8'hE0, 32'h1AB);
    rd(8'hE0, 32'hAB, "R5 spurious low byte");
    rd(8'hA0, 32'hAB, "R5 programmed spurious on empty");

    // ignored writes
    sp[9] = 5'd12; fwd(9);
    wr(8'hA0, 32'h0);
    wr(8'h90, 32'hFFFF);
    chk("R9 irq unchanged", 64'(cpu_irq), 64'd1);
    rd(8'h80, 32'h3, "R9 task priority unchanged");
    rd(8'hA0, 32'h29, "R9 pending survives writes");
    chk("R10 irq low", 64'(cpu_irq), 64'd0);

    // EOI retires most urgent in-service
    sp[10] = 5'd20; fwd(10);
    chk("R4 higher forward asserts", 64'(cpu_irq), 64'd1);
    sp[11] = 5'd15; fwd(11);
    rd(8'hA0, 32'h2A, "R1 highest priority chosen");
    chk("R10 pending below in-service", 64'(cpu_irq), 64'd0);
    wr(8'hB0, 32'h0);
    chk("R8 retire highest reasserts", 64'(cpu_irq), 64'd1);
    rd(8'hA0, 32'h2B, "R8 remaining pending vector");
    chk("R10 irq low", 64'(cpu_irq), 64'd0);
    wr(8'hB0, 32'h0);
    wr(8'hB0, 32'h0);
    chk("R8 irq low when all ended", 64'(cpu_irq), 64'd0);
    rd(8'hA0, 32'hAB, "R5 empty after all");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule